// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register Block

This block holds a table of 64-bit interrupt routing entries and makes it reachable from a host bus that offers only two 32-bit locations. The first location, at offset 0x00, is a select register. The second, at offset 0x10, is a data window. Software writes an index into the select register and then reads or writes the window. Besides the routing table, the window reaches three words: a writable identifier, a read-only version word and a read-only arbitration word.

Every entry is exported on a flat bus to a delivery engine, which sits outside this block. The engine owns two status bits in each entry, remote IRR and delivery status. It updates them through per-entry set and clear strobes, and host writes cannot alter them. Two write side effects are implemented:

- A write that leaves an entry in edge mode clears that entry's remote IRR.
- A write that changes any bit other than mask or polarity raises a one-cycle change pulse, together with the pin number, so that downstream trigger-mode state can be rebuilt.

Top module: `irq_route_regs`

## Requirements
- R1: Only accesses with `host_bytes` = 4 at offset 0x00 or 0x10 take effect. Any other size or offset leaves all state unchanged on a write, and returns zero on a read.
- R2: The select register stores and reads back all 32 written bits. Only its bits [7:0] form the window index.
- R3: Window index 0x00 is the identifier. A write keeps only data bits [27:24], and a read returns those bits in place with all other bits zero. Window index 0x02 reads the same value as index 0x00, and writes to index 0x02 are ignored.
- R4: Window index 0x01 reads ((NUM_PINS−1)<<16)|0x11, which is 0x001F0011 for 32 pins. Writes to index 0x01 are ignored.
- R5: Entry n is reached at window index 0x10+2n for bits [31:0] and at 0x11+2n for bits [63:32]. A write replaces only the addressed half. Indices 0x03–0x0F, and indices at or above 0x10+2·NUM_PINS, read zero.
- R6: After reset every entry holds 0x0001000000010000, which has the mask bit (16) set.
- R7: Host writes never change remote IRR (bit 14) or delivery status (bit 12). The strobes `irr_set`/`irr_clr` and `dlv_set`/`dlv_clr` update these bits at the next clock edge. When set and clear are asserted together, clear wins.
- R8: When a write leaves trigger mode (bit 15) at 0, meaning edge, remote IRR is cleared at that edge. This takes priority over an `irr_set` in the same cycle. A write that leaves bit 15 at 1 (level) lets a same-cycle `irr_set` take effect.
- R9: `cfg_changed` is high for exactly the one cycle after a write, with `cfg_changed_pin` = the entry number. It rises only when that write changed some entry bit other than mask (16) and polarity (13); a remote IRR clear caused by R8 counts as a change. Status strobes never raise it.
- R10: `route_table[64n+63:64n]` carries entry n. It reflects a write from the edge at which the write is taken.
- R11: Every read access, whether accepted or not, pulses `host_rvalid` for one cycle after the access, with `host_rdata` holding the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_bytes | input | 3 | Access size in bytes |
| host_offset | input | ADDR_W | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response pulse |
| irr_set | input | NUM_PINS | Per-entry remote IRR set strobe |
| irr_clr | input | NUM_PINS | Per-entry remote IRR clear strobe |
| dlv_set | input | NUM_PINS | Per-entry delivery status set strobe |
| dlv_clr | input | NUM_PINS | Per-entry delivery status clear strobe |
| route_table | output | 64·NUM_PINS | All entries, entry n at bits [64n+63:64n] |
| cfg_changed | output | 1 | Routing-relevant change pulse |
| cfg_changed_pin | output | PIN_W | Entry that changed |

## Verification
Two things can happen to one entry in the same cycle: a host window write, and a remote IRR set from the delivery engine. The bench drives both in the same cycle twice. In the first case the write selects edge mode, so the entry must come back with remote IRR clear and no change pulse, because nothing else differed. In the second case the write selects level mode, so the set must land and the change pulse must fire for the trigger bit. A further case raises remote IRR on an edge-mode entry and then rewrites the entry with unchanged data. The bench checks that the side-effect clear alone produces the change pulse.

// File: rtl/irt_pkg.sv
package irt_pkg;

    // Layout of one routing entry, most significant field first
    typedef struct packed {
        logic [7:0]  dest;    // 63:56
        logic [38:0] resv;    // 55:17
        logic        mask;    // 16
        logic        trig;    // 15, 1 = level
        logic        irr;     // 14, engine owned
        logic        pol;     // 13
        logic        dlvs;    // 12, engine owned
        logic        dmode;   // 11
        logic [2:0]  dlvm;    // 10:8
        logic [7:0]  vec;     // 7:0
    } irt_entry_t;

    localparam logic [63:0] ENTRY_RESET = 64'h0001_0000_0001_0000;
    localparam logic [63:0] CHG_IGNORE  = 64'h0000_0000_0001_2000;

    localparam int          WIN_IDX_W = 8;
    localparam int          ID_LSB    = 24;
    localparam int          ID_W      = 4;

    localparam logic [WIN_IDX_W-1:0] IDX_ID  = 8'h00;
    localparam logic [WIN_IDX_W-1:0] IDX_VER = 8'h01;
    localparam logic [WIN_IDX_W-1:0] IDX_ARB = 8'h02;
    localparam logic [WIN_IDX_W-1:0] IDX_TBL = 8'h10;

    localparam logic [2:0] ACC_BYTES = 3'd4;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_WIN  = 2'd2
    } acc_kind_e;

    function automatic logic [31:0] id_word(input logic [ID_W-1:0] id);
        logic [31:0] w;
        w = '0;
        w[ID_LSB +: ID_W] = id;
        return w;
    endfunction

    function automatic logic [31:0] ver_word(input int pins);
        logic [31:0] w;
        w = 32'h0000_0011;
        w[23:16] = 8'(pins - 1);
        return w;
    endfunction

endpackage

// File: rtl/irt_host_decode.sv
module irt_host_decode
    import irt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [2:0]        bytes_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic              sel_wr_o,
    output logic              sel_rd_o,
    output logic              win_wr_o,
    output logic              win_rd_o,
    output logic              rd_any_o
);
    localparam logic [ADDR_W-1:0] OFF_SEL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(8'h10);

    acc_kind_e kind;

    always_comb begin
        kind = ACC_NONE;
        if (valid_i && bytes_i == ACC_BYTES) begin
            if (offset_i == OFF_SEL)      kind = ACC_SEL;
            else if (offset_i == OFF_WIN) kind = ACC_WIN;
        end
    end

    assign sel_wr_o = (kind == ACC_SEL) &&  write_i;
    assign sel_rd_o = (kind == ACC_SEL) && !write_i;
    assign win_wr_o = (kind == ACC_WIN) &&  write_i;
    assign win_rd_o = (kind == ACC_WIN) && !write_i;
    assign rd_any_o = valid_i && !write_i;

endmodule

// File: rtl/irt_entry.sv
module irt_entry
    import irt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo_i,
    input  logic        wr_hi_i,
    input  logic [31:0] wdata_i,
    input  logic        irr_set_i,
    input  logic        irr_clr_i,
    input  logic        dlv_set_i,
    input  logic        dlv_clr_i,
    output irt_entry_t  q_o,
    output logic        chg_o
);
    irt_entry_t q_r, wv, nxt;
    logic [63:0] raw;
    logic        wr, edge_clr, chg_d;

    assign wr = wr_lo_i | wr_hi_i;

    always_comb begin
        raw = q_r;
        if (wr_lo_i) raw[31:0]  = wdata_i;
        if (wr_hi_i) raw[63:32] = wdata_i;
        wv      = irt_entry_t'(raw);
        wv.irr  = q_r.irr;
        wv.dlvs = q_r.dlvs;
        edge_clr = wr && !wv.trig;
        if (edge_clr) wv.irr = 1'b0;
        chg_d = wr && (((q_r ^ wv) & ~CHG_IGNORE) != 64'd0);

        nxt      = wv;
        nxt.dlvs = (q_r.dlvs | dlv_set_i) & ~dlv_clr_i;
        if (!edge_clr) nxt.irr = (q_r.irr | irr_set_i) & ~irr_clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= irt_entry_t'(ENTRY_RESET);
            chg_o <= 1'b0;
        end else begin
            q_r   <= nxt;
            chg_o <= chg_d;
        end
    end

    assign q_o = q_r;

    AST_IRR_HOST_RO: assert property (@(posedge clk) disable iff (rst)
        (wr && !irr_set_i) |=> !$rose(q_r.irr));                    // R7
    AST_DLV_HOST_RO: assert property (@(posedge clk) disable iff (rst)
        (wr && !dlv_set_i && !dlv_clr_i) |=> $stable(q_r.dlvs));   // R7
    AST_EDGE_NO_IRR: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q_r.trig || !q_r.irr));                             // R8
    AST_CHG_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        chg_o |-> $past(wr));                                       // R9

endmodule

// File: rtl/irt_win_read.sv
module irt_win_read
    import irt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [WIN_IDX_W-1:0]  idx_i,
    input  logic [ID_W-1:0]       id_i,
    input  logic [NUM_PINS*64-1:0] table_i,
    output logic [31:0]           data_o
);
    localparam int WORDS = 2 * NUM_PINS;

    int off;

    always_comb begin
        off    = int'(idx_i) - int'(IDX_TBL);
        data_o = 32'd0;
        if (idx_i == IDX_ID || idx_i == IDX_ARB) begin
            data_o = id_word(id_i);
        end else if (idx_i == IDX_VER) begin
            data_o = ver_word(NUM_PINS);
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (off == w) data_o = table_i[w*32 +: 32];
            end
        end
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_valid,
    input  logic                   host_write,
    input  logic [2:0]             host_bytes,
    input  logic [ADDR_W-1:0]      host_offset,
    input  logic [31:0]            host_wdata,
    output logic [31:0]            host_rdata,
    output logic                   host_rvalid,
    input  logic [NUM_PINS-1:0]    irr_set,
    input  logic [NUM_PINS-1:0]    irr_clr,
    input  logic [NUM_PINS-1:0]    dlv_set,
    input  logic [NUM_PINS-1:0]    dlv_clr,
    output logic [NUM_PINS*64-1:0] route_table,
    output logic                   cfg_changed,
    output logic [PIN_W-1:0]       cfg_changed_pin
);
    logic                 sel_wr, sel_rd, win_wr, win_rd, rd_any;
    logic [31:0]          sel_q;
    logic [ID_W-1:0]      id_q;
    logic [31:0]          win_data;
    logic [NUM_PINS-1:0]  chg_vec;
    logic [WIN_IDX_W-1:0] idx;

    assign idx = sel_q[WIN_IDX_W-1:0];

    irt_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid_i  (host_valid),
        .write_i  (host_write),
        .bytes_i  (host_bytes),
        .offset_i (host_offset),
        .sel_wr_o (sel_wr),
        .sel_rd_o (sel_rd),
        .win_wr_o (win_wr),
        .win_rd_o (win_rd),
        .rd_any_o (rd_any)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam logic [WIN_IDX_W-1:0] LO_IDX = WIN_IDX_W'(int'(IDX_TBL) + 2*n);
        localparam logic [WIN_IDX_W-1:0] HI_IDX = WIN_IDX_W'(int'(IDX_TBL) + 2*n + 1);
        irt_entry_t q;

        irt_entry u_ent (
            .clk       (clk),
            .rst       (rst),
            .wr_lo_i   (win_wr && idx == LO_IDX),
            .wr_hi_i   (win_wr && idx == HI_IDX),
            .wdata_i   (host_wdata),
            .irr_set_i (irr_set[n]),
            .irr_clr_i (irr_clr[n]),
            .dlv_set_i (dlv_set[n]),
            .dlv_clr_i (dlv_clr[n]),
            .q_o       (q),
            .chg_o     (chg_vec[n])
        );
        assign route_table[n*64 +: 64] = q;
    end

    irt_win_read #(.NUM_PINS(NUM_PINS)) u_rd (
        .idx_i   (idx),
        .id_i    (id_q),
        .table_i (route_table),
        .data_o  (win_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q       <= 32'd0;
            id_q        <= '0;
            host_rdata  <= 32'd0;
            host_rvalid <= 1'b0;
        end else begin
            if (sel_wr) sel_q <= host_wdata;
            if (win_wr && idx == IDX_ID) id_q <= host_wdata[ID_LSB +: ID_W];
            host_rvalid <= rd_any;
            if (rd_any) begin
                host_rdata <= sel_rd ? sel_q : (win_rd ? win_data : 32'd0);
            end
        end
    end

    always_comb begin
        cfg_changed_pin = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (chg_vec[n]) cfg_changed_pin = PIN_W'(n);
        end
    end
    assign cfg_changed = |chg_vec;

    AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg_vec));                                              // R9
    AST_RD_ACK: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write) |=> host_rvalid);                   // R11
    AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write && host_bytes != ACC_BYTES)
        |=> host_rdata == 32'd0);                                       // R1

endmodule

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
    localparam int N = 32;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_valid = 1'b0;
    logic          host_write = 1'b0;
    logic [2:0]    host_bytes = 3'd0;
    logic [7:0]    host_offset = 8'd0;
    logic [31:0]   host_wdata = 32'd0;
    logic [31:0]   host_rdata;
    logic          host_rvalid;
    logic [N-1:0]  irr_set = '0, irr_clr = '0, dlv_set = '0, dlv_clr = '0;
    logic [N*64-1:0] route_table;
    logic          cfg_changed;
    logic [PW-1:0] cfg_changed_pin;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] got_rdata;
    logic        got_rvalid, got_chg;
    logic [PW-1:0] got_pin;

    irq_route_regs #(.NUM_PINS(N), .ADDR_W(8)) uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with results captured
    task automatic bus_op(input logic wr, input logic [7:0] off, input logic [2:0] nb,
                          input logic [31:0] d);
        host_valid = 1'b1; host_write = wr; host_bytes = nb;
        host_offset = off; host_wdata = d;
        @(negedge clk);
        got_rdata = host_rdata; got_rvalid = host_rvalid;
        got_chg = cfg_changed; got_pin = cfg_changed_pin;
        host_valid = 1'b0; host_write = 1'b0;
        irr_set = '0; irr_clr = '0; dlv_set = '0; dlv_clr = '0;
    endtask

    task automatic eng_op(input logic [N-1:0] si, input logic [N-1:0] ci,
                          input logic [N-1:0] sd, input logic [N-1:0] cd);
        irr_set = si; irr_clr = ci; dlv_set = sd; dlv_clr = cd;
        @(negedge clk);
        got_chg = cfg_changed;
        irr_set = '0; irr_clr = '0; dlv_set = '0; dlv_clr = '0;
    endtask

    task automatic rd_win(input logic [7:0] idx);
        bus_op(1'b1, 8'h00, 3'd4, {24'd0, idx});
        bus_op(1'b0, 8'h10, 3'd4, 32'd0);
    endtask

    task automatic wr_win(input logic [7:0] idx, input logic [31:0] d, input logic [N-1:0] si);
        bus_op(1'b1, 8'h00, 3'd4, {24'd0, idx});
        irr_set = si;
        bus_op(1'b1, 8'h10, 3'd4, d);
    endtask

    task automatic t_reset;
        chk("R11 rvalid idle", {63'd0, host_rvalid}, 64'd0);
        chk("R9 no change at reset", {63'd0, cfg_changed}, 64'd0);
        chk("R6 R10 entry 31 export", route_table[31*64 +: 64], 64'h0001_0000_0001_0000);
        rd_win(8'h10);
        chk("R6 entry 0 low", {32'd0, got_rdata}, 64'h0001_0000);
        chk("R11 rvalid on read", {63'd0, got_rvalid}, 64'd1);
        rd_win(8'h4F);
        chk("R6 entry 31 high", {32'd0, got_rdata}, 64'h0001_0000);
    endtask

    task automatic t_access;
        bus_op(1'b1, 8'h00, 3'd4, 32'h12);
        chk("R11 no rvalid on write", {63'd0, got_rvalid}, 64'd0);
        bus_op(1'b1, 8'h00, 3'd2, 32'h34);
        bus_op(1'b0, 8'h00, 3'd4, 32'd0);
        chk("R1 short select write ignored", {32'd0, got_rdata}, 64'h12);
        bus_op(1'b0, 8'h08, 3'd4, 32'd0);
        chk("R1 bad offset reads zero", {32'd0, got_rdata}, 64'd0);
        chk("R1 R11 bad offset rvalid", {63'd0, got_rvalid}, 64'd1);
        bus_op(1'b1, 8'h00, 3'd4, 32'h0);
        bus_op(1'b0, 8'h10, 3'd1, 32'd0);
        chk("R1 byte window read zero", {32'd0, got_rdata}, 64'd0);
        bus_op(1'b1, 8'h10, 3'd2, 32'h0F00_0000);
        rd_win(8'h00);
        chk("R1 short window write ignored", {32'd0, got_rdata}, 64'd0);
    endtask

    task automatic t_select_version;
        bus_op(1'b1, 8'h00, 3'd4, 32'h0000_0301);
        bus_op(1'b0, 8'h00, 3'd4, 32'd0);
        chk("R2 select readback", {32'd0, got_rdata}, 64'h301);
        bus_op(1'b0, 8'h10, 3'd4, 32'd0);
        chk("R2 R4 low byte index to version", {32'd0, got_rdata}, 64'h001F_0011);
        bus_op(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
        bus_op(1'b0, 8'h10, 3'd4, 32'd0);
        chk("R4 version read-only", {32'd0, got_rdata}, 64'h001F_0011);
    endtask

    task automatic t_id;
        wr_win(8'h00, 32'hFFFF_FFFF, '0);
        rd_win(8'h00);
        chk("R3 id masked", {32'd0, got_rdata}, 64'h0F00_0000);
        wr_win(8'h02, 32'h0, '0);
        rd_win(8'h02);
        chk("R3 arb mirrors id", {32'd0, got_rdata}, 64'h0F00_0000);
        rd_win(8'h00);
        chk("R3 arb write ignored", {32'd0, got_rdata}, 64'h0F00_0000);
    endtask

    task automatic t_layout;
        rd_win(8'h03);
        chk("R5 gap index zero", {32'd0, got_rdata}, 64'd0);
        rd_win(8'h50);
        chk("R5 past table zero", {32'd0, got_rdata}, 64'd0);
        rd_win(8'hFF);
        chk("R5 top index zero", {32'd0, got_rdata}, 64'd0);
        wr_win(8'h1A, 32'h0000_A031, '0);
        chk("R9 pulse on vector write", {63'd0, got_chg}, 64'd1);
        chk("R9 pin number", {59'd0, got_pin}, 64'd5);
        @(negedge clk);
        chk("R9 single cycle", {63'd0, cfg_changed}, 64'd0);
        rd_win(8'h1A);
        chk("R5 entry 5 low", {32'd0, got_rdata}, 64'hA031);
        rd_win(8'h1B);
        chk("R5 entry 5 high untouched", {32'd0, got_rdata}, 64'h0001_0000);
        wr_win(8'h1B, 32'h7F00_0000, '0);
        chk("R9 pulse on dest write", {63'd0, got_chg}, 64'd1);
        chk("R10 export after write", route_table[5*64 +: 64], 64'h7F00_0000_0000_A031);
        rd_win(8'h1A);
        chk("R5 low kept on high write", {32'd0, got_rdata}, 64'hA031);
    endtask

    task automatic t_status;
        logic [N-1:0] p5;
        p5 = '0; p5[5] = 1'b1;
        wr_win(8'h1A, 32'h0000_F031, '0);
        chk("R9 no pulse when only RO bits written", {63'd0, got_chg}, 64'd0);
        rd_win(8'h1A);
        chk("R7 RO bits not written", {32'd0, got_rdata}, 64'hA031);
        eng_op(p5, '0, '0, '0);
        chk("R9 no pulse on status set", {63'd0, got_chg}, 64'd0);
        rd_win(8'h1A);
        chk("R7 irr set", {32'd0, got_rdata}, 64'hE031);
        eng_op('0, '0, p5, '0);
        rd_win(8'h1A);
        chk("R7 dlv set", {32'd0, got_rdata}, 64'hF031);
        wr_win(8'h1A, 32'h0000_A031, '0);
        rd_win(8'h1A);
        chk("R7 write cannot clear status", {32'd0, got_rdata}, 64'hF031);
        eng_op(p5, p5, p5, p5);
        rd_win(8'h1A);
        chk("R7 clear wins over set", {32'd0, got_rdata}, 64'hA031);
    endtask

    task automatic t_maskpol;
        wr_win(8'h1A, 32'h0001_A031, '0);
        chk("R9 mask only no pulse", {63'd0, got_chg}, 64'd0);
        wr_win(8'h1A, 32'h0001_8031, '0);
        chk("R9 polarity only no pulse", {63'd0, got_chg}, 64'd0);
        wr_win(8'h1A, 32'h0000_A031, '0);
        chk("R9 restore no pulse", {63'd0, got_chg}, 64'd0);
        rd_win(8'h1A);
        chk("R9 entry restored", {32'd0, got_rdata}, 64'hA031);
    endtask

    task automatic t_edge;
        logic [N-1:0] p5, p7;
        p5 = '0; p5[5] = 1'b1;
        p7 = '0; p7[7] = 1'b1;
        eng_op(p5, '0, '0, '0);
        wr_win(8'h1A, 32'h0000_2031, '0);
        chk("R8 R9 edge write pulses", {63'd0, got_chg}, 64'd1);
        rd_win(8'h1A);
        chk("R8 edge write clears irr", {32'd0, got_rdata}, 64'h2031);
        wr_win(8'h1A, 32'h0000_2031, p5);
        chk("R8 R9 edge write with set no pulse", {63'd0, got_chg}, 64'd0);
        rd_win(8'h1A);
        chk("R8 edge clear beats set", {32'd0, got_rdata}, 64'h2031);
        wr_win(8'h1A, 32'h0000_A031, p5);
        chk("R9 level write pulses", {63'd0, got_chg}, 64'd1);
        rd_win(8'h1A);
        chk("R8 level write keeps same-cycle set", {32'd0, got_rdata}, 64'hE031);
        eng_op(p7, '0, '0, '0);
        rd_win(8'h1E);
        chk("R7 irr set on edge entry", {32'd0, got_rdata}, 64'h0001_4000);
        wr_win(8'h1F, 32'h0001_0000, '0);
        chk("R9 side-effect clear pulses", {63'd0, got_chg}, 64'd1);
        chk("R9 side-effect pin", {59'd0, got_pin}, 64'd7);
        rd_win(8'h1E);
        chk("R8 high write clears irr in edge", {32'd0, got_rdata}, 64'h0001_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_access();
        t_select_version();
        t_id();
        t_layout();
        t_status();
        t_maskpol();
        t_edge();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule